// File: doc/BRIEF.md
# Toroidal Word-Array Shifter

This block holds a square grid of N by N data words (16 bits each by default) and moves the whole grid one cell position per clock in a chosen direction. A word pushed off one edge of the grid comes back in at the opposite edge, so the grid behaves as a torus. It is used to fine-position an image before the image goes on for comparison. The array is first filled in one cycle from a wide parallel input, then nudged by a command, and then read back through a registered parallel output.

A command gives a direction and a step count K. The block then performs K single-cell moves of the entire grid on consecutive clocks and signals completion with a one-cycle pulse. A count of zero finishes at once and leaves the grid untouched. A parallel load always wins. It replaces the grid contents and cancels any command that is still running.

Top module: `torus_shifter`

## Requirements
- R1: After synchronous reset every word of the grid reads zero, and `busy` and `done` are low.
- R2: With `load_en` high at a clock edge, the word at row r, column c of the grid becomes `load_data[(r*N+c)*W +: W]` and shows on `arr_out` at the same position after that edge.
- R3: Direction code 2'b00 (right) moves every word one column up in index: cell (r,c) takes the value of cell (r,c-1), and column 0 takes the value from column N-1.
- R4: Direction code 2'b01 (left): cell (r,c) takes the value of cell (r,c+1), and column N-1 takes the value from column 0.
- R5: Direction code 2'b10 (up): cell (r,c) takes the value of cell (r+1,c), and row N-1 takes the value from row 0.
- R6: Direction code 2'b11 (down): cell (r,c) takes the value of cell (r-1,c), and row 0 takes the value from row N-1.
- R7: A `step_go` pulse accepted while idle, with count K > 0, holds `busy` high for K cycles. The block performs one whole-grid move at each of the K edges that follow acceptance. `done` is high for exactly the one cycle after the last move, and `busy` and `done` are never high together.
- R8: A `step_go` accepted with count 0 raises `done` for one cycle on the next edge, never raises `busy`, and leaves the grid unchanged.
- R9: `load_en` has priority. It cancels a running command: `busy` drops, no further moves occur and no `done` follows. A `step_go` in the same cycle as `load_en` is ignored.
- R10: A `step_go` that arrives while `busy` is high is ignored. The running command keeps its direction and count.
- R11: When the block is idle and `load_en` is low, the grid holds its contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Parallel load strobe (highest priority) |
| load_data | input | N*N*W | Full grid image, cell (r,c) at bits (r*N+c)*W |
| dir | input | 2 | Move direction: 00 right, 01 left, 10 up, 11 down |
| step_go | input | 1 | Start strobe for a move command |
| step_cnt | input | CW | Number of single-cell moves for the command |
| arr_out | output | N*N*W | Registered grid contents, same layout as load_data |
| busy | output | 1 | High while a command is still moving the grid |
| done | output | 1 | One-cycle pulse when a command completes |

## Verification
The bench builds the block with N=4, W=16 and a 6-bit count. At that size a move of exactly N steps must bring the grid back to its starting image, and a move of N+1 steps must wrap past that point, so whole-cycle wraparound is tested in both axes. The 6-bit count allows moves longer than the grid while the run stays short. The small grid also puts every cell on an edge or one step from an edge, so each wrap path is covered.

// File: rtl/torus_pkg.sv
package torus_pkg;
  typedef enum logic [1:0] {
    DIR_RIGHT = 2'b00,
    DIR_LEFT  = 2'b01,
    DIR_UP    = 2'b10,
    DIR_DOWN  = 2'b11
  } dir_e;
endpackage

// File: rtl/torus_cell.sv
module torus_cell
  import torus_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_en,
  input  logic [W-1:0] load_word,
  input  logic         shift_en,
  input  dir_e         shift_dir,
  input  logic [W-1:0] from_west,
  input  logic [W-1:0] from_east,
  input  logic [W-1:0] from_south,
  input  logic [W-1:0] from_north,
  output logic [W-1:0] q
);
  logic [W-1:0] moved;
  logic [W-1:0] nxt;

  // Source of the word that lands in this cell for a move
  always_comb begin
    unique case (shift_dir)
      DIR_RIGHT: moved = from_west;
      DIR_LEFT:  moved = from_east;
      DIR_UP:    moved = from_south;
      default:   moved = from_north;
    endcase
  end

  always_comb begin
    if (load_en)       nxt = load_word;
    else if (shift_en) nxt = moved;
    else               nxt = q;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/torus_seq.sv
module torus_seq
  import torus_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_en,
  input  logic          step_go,
  input  logic [1:0]    dir,
  input  logic [CW-1:0] step_cnt,
  output logic          busy,
  output logic          done,
  output logic          shift_en,
  output dir_e          shift_dir
);
  logic [CW-1:0] rem;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      rem       <= '0;
      shift_dir <= DIR_RIGHT;
    end else begin
      done <= 1'b0;
      if (load_en) begin
        busy <= 1'b0;
        rem  <= '0;
      end else if (busy) begin
        rem <= rem - CW'(1);
        if (rem == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (step_go) begin
        shift_dir <= dir_e'(dir);
        rem       <= step_cnt;
        if (step_cnt == '0) done <= 1'b1;
        else                busy <= 1'b1;
      end
    end
  end

  assign shift_en = busy && !load_en;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy && done)); // R7
  AST_ZERO_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
    (step_go && !busy && !load_en && step_cnt == '0) |=> (done && !busy)); // R8
  AST_LOAD_ABORTS: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (!busy && !done)); // R9
  AST_GO_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && step_go && !load_en) |=> $stable(shift_dir)); // R10
endmodule

// File: rtl/torus_shifter.sv
module torus_shifter
  import torus_pkg::*;
#(
  parameter int N  = 4,
  parameter int W  = 16,
  parameter int CW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [N*N*W-1:0]  load_data,
  input  logic [1:0]        dir,
  input  logic              step_go,
  input  logic [CW-1:0]     step_cnt,
  output logic [N*N*W-1:0]  arr_out,
  output logic              busy,
  output logic              done
);
  localparam int CELLS = N * N;
  localparam int BITS  = CELLS * W;

  logic [BITS-1:0] grid;
  logic            shift_en;
  dir_e            shift_dir;

  torus_seq #(.CW(CW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .load_en   (load_en),
    .step_go   (step_go),
    .dir       (dir),
    .step_cnt  (step_cnt),
    .busy      (busy),
    .done      (done),
    .shift_en  (shift_en),
    .shift_dir (shift_dir)
  );

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      localparam int IDX = r * N + c;
      localparam int IW  = r * N + ((c + N - 1) % N);
      localparam int IE  = r * N + ((c + 1) % N);
      localparam int IS  = ((r + 1) % N) * N + c;
      localparam int INO = ((r + N - 1) % N) * N + c;
      torus_cell #(.W(W)) u_cell (
        .clk        (clk),
        .rst        (rst),
        .load_en    (load_en),
        .load_word  (load_data[IDX*W +: W]),
        .shift_en   (shift_en),
        .shift_dir  (shift_dir),
        .from_west  (grid[IW*W +: W]),
        .from_east  (grid[IE*W +: W]),
        .from_south (grid[IS*W +: W]),
        .from_north (grid[INO*W +: W]),
        .q          (grid[IDX*W +: W])
      );
    end
  end

  assign arr_out = grid;

  // Corner cells used to watch the wrap paths
  localparam int C00 = 0;
  localparam int C0L = N - 1;
  localparam int CL0 = (N - 1) * N;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy && !load_en) |=> $stable(grid)); // R11
  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (grid == $past(load_data))); // R2
  AST_WRAP_RIGHT: assert property (@(posedge clk) disable iff (rst)
    (shift_en && shift_dir == DIR_RIGHT) |=>
      (grid[C00*W +: W] == $past(grid[C0L*W +: W]))); // R3
  AST_WRAP_LEFT: assert property (@(posedge clk) disable iff (rst)
    (shift_en && shift_dir == DIR_LEFT) |=>
      (grid[C0L*W +: W] == $past(grid[C00*W +: W]))); // R4
  AST_WRAP_UP: assert property (@(posedge clk) disable iff (rst)
    (shift_en && shift_dir == DIR_UP) |=>
      (grid[CL0*W +: W] == $past(grid[C00*W +: W]))); // R5
  AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (shift_en && shift_dir == DIR_DOWN) |=>
      (grid[C00*W +: W] == $past(grid[CL0*W +: W]))); // R6
  AST_ZERO_STABLE: assert property (@(posedge clk) disable iff (rst)
    (step_go && !busy && !load_en && step_cnt == '0) |=> $stable(grid)); // R8
endmodule

// File: tb/sim_torus_shifter.sv
`timescale 1ns/1ps
module sim_torus_shifter;
  localparam int N  = 4;
  localparam int W  = 16;
  localparam int CW = 6;
  localparam int CELLS = N * N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load_en = 1'b0;
  logic [CELLS*W-1:0] load_data = '0;
  logic [1:0] dir = 2'b00;
  logic step_go = 1'b0;
  logic [CW-1:0] step_cnt = '0;
  logic [CELLS*W-1:0] arr_out;
  logic busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  torus_shifter #(.N(N), .W(W), .CW(CW)) u0 (
    .clk(clk), .rst(rst), .load_en(load_en), .load_data(load_data),
    .dir(dir), .step_go(step_go), .step_cnt(step_cnt),
    .arr_out(arr_out), .busy(busy), .done(done)
  );

  // Behavioural reference model
  logic [W-1:0] m [CELLS];
  bit m_busy, m_done;
  int m_rem;
  int m_dir;

  function automatic int wrap(int x);
    return ((x % N) + N) % N;
  endfunction

  task automatic model_move(int d);
    logic [W-1:0] t [CELLS];
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        case (d)
          0: t[r*N+c] = m[r*N+wrap(c-1)];
          1: t[r*N+c] = m[r*N+wrap(c+1)];
          2: t[r*N+c] = m[wrap(r+1)*N+c];
          default: t[r*N+c] = m[wrap(r-1)*N+c];
        endcase
      end
    for (int i = 0; i < CELLS; i++) m[i] = t[i];
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CELLS; i++) m[i] = '0;
      m_busy = 0; m_done = 0; m_rem = 0; m_dir = 0;
    end else begin
      m_done = 0;
      if (load_en) begin
        for (int i = 0; i < CELLS; i++) m[i] = load_data[i*W +: W];
        m_busy = 0;
      end else if (m_busy) begin
        model_move(m_dir);
        m_rem = m_rem - 1;
        if (m_rem == 0) begin m_busy = 0; m_done = 1; end
      end else if (step_go) begin
        m_dir = int'(dir);
        m_rem = int'(step_cnt);
        if (m_rem == 0) m_done = 1; else m_busy = 1;
      end
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      logic [CELLS*W-1:0] exp_flat;
      for (int i = 0; i < CELLS; i++) exp_flat[i*W +: W] = m[i];
      checks++;
      if (arr_out !== exp_flat) begin
        errors++;
        $display("FAIL %s grid actual=%h expected=%h", cur_req, arr_out, exp_flat);
      end
      checks++;
      if (busy !== m_busy || done !== m_done) begin
        errors++;
        $display("FAIL %s busy/done actual=%b%b expected=%b%b", cur_req,
                 busy, done, m_busy, m_done);
      end
    end
  end

  // Independent pattern bookkeeping for explicit checks
  int base;
  int orow, ocol;

  function automatic logic [CELLS*W-1:0] make_pat(int b);
    logic [CELLS*W-1:0] v;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        v[(r*N+c)*W +: W] = W'(b + r*16 + c);
    return v;
  endfunction

  task automatic check_grid(string tag);
    logic [CELLS*W-1:0] e;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        e[(r*N+c)*W +: W] = W'(base + wrap(r-orow)*16 + wrap(c-ocol));
    checks++;
    if (arr_out !== e) begin
      errors++;
      $display("FAIL %s explicit grid actual=%h expected=%h", tag, arr_out, e);
    end
  endtask

  task automatic do_load(int b);
    @(negedge clk);
    load_en = 1'b1; load_data = make_pat(b);
    @(negedge clk);
    load_en = 1'b0;
    base = b; orow = 0; ocol = 0;
  endtask

  task automatic do_move(int d, int k);
    int guard;
    @(negedge clk);
    step_go = 1'b1; dir = 2'(d); step_cnt = CW'(k);
    @(negedge clk);
    step_go = 1'b0;
    guard = 0;
    while (!done && guard < 200) begin @(negedge clk); guard++; end
    case (d)
      0: ocol += k;
      1: ocol -= k;
      2: orow -= k;
      default: orow += k;
    endcase
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    checks++;
    if (arr_out !== '0 || busy !== 1'b0 || done !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset actual=%h %b%b expected=0 00", arr_out, busy, done);
    end

    cur_req = "R2"; do_load(16'h1000); check_grid("R2");
    cur_req = "R3"; do_move(0, 1); check_grid("R3");
    cur_req = "R4"; do_move(1, 1); check_grid("R4");
    cur_req = "R5"; do_move(2, 1); check_grid("R5");
    cur_req = "R6"; do_move(3, 1); check_grid("R6");
    cur_req = "R7"; do_move(0, 3); check_grid("R7");
    do_move(2, N);     check_grid("R7");
    do_move(3, N + 1); check_grid("R7");
    do_move(1, 2 * N + 3); check_grid("R7");

    // R8 zero count: done next edge, grid unchanged
    cur_req = "R8"; do_move(2, 0); check_grid("R8");

    // R10 go while busy is ignored
    cur_req = "R10";
    @(negedge clk); step_go = 1'b1; dir = 2'b00; step_cnt = CW'(4);
    @(negedge clk); dir = 2'b11; step_cnt = CW'(9);
    @(negedge clk); step_go = 1'b0;
    while (!done) @(negedge clk);
    ocol += 4; check_grid("R10");

    // R9 load cancels a running command
    cur_req = "R9";
    @(negedge clk); step_go = 1'b1; dir = 2'b01; step_cnt = CW'(6);
    @(negedge clk); step_go = 1'b0;
    @(negedge clk);
    load_en = 1'b1; load_data = make_pat(16'h5500);
    @(negedge clk); load_en = 1'b0;
    base = 16'h5500; orow = 0; ocol = 0;
    checks++;
    if (busy !== 1'b0) begin
      errors++;
      $display("FAIL R9 busy after load actual=%b expected=0", busy);
    end
    repeat (8) @(negedge clk);
    check_grid("R9");
    // R9 load with step_go in the same cycle
    load_en = 1'b1; step_go = 1'b1; dir = 2'b10; step_cnt = CW'(2);
    load_data = make_pat(16'h7700);
    @(negedge clk); load_en = 1'b0; step_go = 1'b0;
    base = 16'h7700;
    repeat (4) @(negedge clk);
    check_grid("R9");

    // R11 idle hold
    cur_req = "R11";
    load_data = make_pat(16'h2200);
    repeat (6) @(negedge clk);
    check_grid("R11");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule